// File: doc/BRIEF.md
# Exclusive Pair Load Execution Unit

This unit takes one 32-bit load-exclusive-pair instruction word, decodes it and carries it out end to end. The base address comes either from a general register, read through a combinational register-file port, or from the stack pointer. When the stack pointer is the base, the unit checks that it is 16-byte aligned. Before the memory read goes out, the unit arms an exclusive monitor with the access address and byte count. It then issues exactly one memory read request of 8 or 16 bytes. The returned data is split into two element-sized results. These are written back through two register write ports, in an order that depends on endianness.

An instruction whose two destination fields name the same register is handled by a policy input. Under that policy the unit either performs the access and writes an all-ones value to that one register, or raises undefined-instruction, or retires the instruction with no effect at all. A separate clear input lets the surrounding logic drop the monitor reservation.

Top module: `xpl_pair_load`

## Requirements
- R1: A word is accepted only when `ins_valid` is high in the idle state. It is recognised when bit31=1, bits29:24=001000, bit23=0, bit22=1, bit21=1, bits20:16=11111 and bit15=0. An unrecognised word pulses `undef_o` for one cycle, in the cycle after acceptance, and causes no request and no writeback.
- R2: Base field bits9:5 equal to 31 selects `sp_val` as the address and drives `mem_req_tagchk` low. Any other value selects `rf_rdata`, read at `rf_raddr` = bits9:5, and drives `mem_req_tagchk` high. No offset is added.
- R3: Size bit 30 set to 0 gives 32-bit elements and `mem_req_bytes` = 8. Set to 1, it gives 64-bit elements and `mem_req_bytes` = 16.
- R4: With the stack pointer as base and `sp_val[3:0]` not zero, `align_fault_o` pulses for one cycle after acceptance. There is no request and no monitor arming, and the unit stays idle. A general-register base is never alignment checked.
- R5: An executing access arms the monitor at the acceptance edge, so `mon_valid`, `mon_addr` and `mon_bytes` show it from the next cycle on. A later arming overwrites the monitor. `mon_clear` drops `mon_valid`, but an arming in the same cycle takes priority.
- R6: `mem_req_valid` rises in the cycle after acceptance. It stays high with a stable address until `mem_req_ready` is sampled high. Each instruction issues exactly one request.
- R7: In little-endian mode (`big_endian`=0, sampled at acceptance), the low element of `mem_rsp_data` goes to port 0, which targets bits4:0. The next element goes to port 1, which targets bits14:10. With 32-bit elements, each value is zero-extended to 64 bits.
- R8: In big-endian mode the two elements are swapped between port 0 and port 1.
- R9: Equal destination fields with `dup_mode`=0 perform the full access and arming. Only port 0 writes, with the value all ones.
- R10: Equal destination fields with `dup_mode`=1 or 3 pulse `undef_o`. There is no request, and the monitor contents are left as they were.
- R11: Equal destination fields with `dup_mode`=2 retire silently: no request, no writeback, no fault and no undef.
- R12: While an access is outstanding, `ins_valid` is ignored.
- R13: Both write enables pulse for one cycle, in the cycle after `mem_rsp_valid` is sampled in the wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction word present |
| ins_word | input | 32 | Instruction word |
| big_endian | input | 1 | Data endianness, sampled at acceptance |
| dup_mode | input | 2 | Policy for equal destinations (0 unknown value, 1/3 undefined, 2 no-op) |
| rf_raddr | output | 5 | Register-file read index (base field) |
| rf_rdata | input | 64 | Register-file read data |
| sp_val | input | 64 | Current stack pointer |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Read address |
| mem_req_bytes | output | 5 | Read byte count (8 or 16) |
| mem_req_tagchk | output | 1 | Access is tag checked |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Read data |
| wb0_en | output | 1 | Write enable, first destination |
| wb0_idx | output | 5 | Register index, first destination |
| wb0_data | output | 64 | Write data, first destination |
| wb1_en | output | 1 | Write enable, second destination |
| wb1_idx | output | 5 | Register index, second destination |
| wb1_data | output | 64 | Write data, second destination |
| undef_o | output | 1 | Undefined-instruction pulse |
| align_fault_o | output | 1 | Stack-pointer alignment fault pulse |
| mon_clear | input | 1 | Clear exclusive reservation |
| mon_valid | output | 1 | Reservation held |
| mon_addr | output | 64 | Reserved address |
| mon_bytes | output | 5 | Reserved byte count |

## Verification
The bench aims at the element split. A unit that ignored endianness, or that took the high element from the wrong offset in 32-bit mode, would write the wrong halves, and a missing zero-extension would leak upper bytes. It misaligns the stack pointer while a general register is the base, which catches a check applied to the wrong source. It also drives a misaligned stack-pointer base, where a faulty unit would still arm the monitor or issue a read. Each equal-destination policy is exercised, together with a monitor-preservation check on the undefined path, and a busy-time instruction that a careless unit would start as a second request.

// File: rtl/xpl_pkg.sv
package xpl_pkg;
  localparam int RIDX_W = 5;
  localparam logic [1:0] DUP_UNKNOWN = 2'd0;
  localparam logic [1:0] DUP_NOP     = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} xpl_state_e;

  typedef struct packed {
    logic              hit;
    logic              wide;
    logic [RIDX_W-1:0] rd0;
    logic [RIDX_W-1:0] rd1;
    logic [RIDX_W-1:0] rbase;
  } xpl_dec_t;

  function automatic xpl_dec_t xpl_decode_word(input logic [31:0] w);
    xpl_dec_t d;
    d.hit   = w[31] && (w[29:24] == 6'b001000) && !w[23] && w[22] && w[21]
              && (&w[20:16]) && !w[15];
    d.wide  = w[30];
    d.rd0   = w[4:0];
    d.rd1   = w[14:10];
    d.rbase = w[9:5];
    return d;
  endfunction
endpackage

// File: rtl/xpl_decode.sv
module xpl_decode
  import xpl_pkg::*;
(
  input  logic [31:0] word,
  output xpl_dec_t    dec
);
  always_comb dec = xpl_decode_word(word);
endmodule

// File: rtl/xpl_monitor.sv
module xpl_monitor #(
  parameter int AW = 64,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] arm_addr,
  input  logic [BW-1:0] arm_bytes,
  input  logic          clr,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] bytes
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      bytes <= '0;
    end else if (arm) begin
      valid <= 1'b1;
      addr  <= arm_addr;
      bytes <= arm_bytes;
    end else if (clr) begin
      valid <= 1'b0;
    end
  end

  assert_arm_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> valid && addr == $past(arm_addr) && bytes == $past(arm_bytes));
  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !arm |=> !valid);
endmodule

// File: rtl/xpl_split.sv
module xpl_split #(
  parameter int XLEN = 64
) (
  input  logic              wide,
  input  logic              be,
  input  logic [2*XLEN-1:0] rdata,
  output logic [XLEN-1:0]   first,
  output logic [XLEN-1:0]   second
);
  localparam int HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] elem(input logic [2*XLEN-1:0] d,
                                           input logic w, input logic upper);
    logic [XLEN-1:0] r;
    if (w) r = upper ? d[2*XLEN-1:XLEN] : d[XLEN-1:0];
    else   r = {{HALF{1'b0}}, (upper ? d[XLEN-1:HALF] : d[HALF-1:0])};
    return r;
  endfunction

  logic [XLEN-1:0] lo_elem, hi_elem;
  always_comb begin
    lo_elem = elem(rdata, wide, 1'b0);
    hi_elem = elem(rdata, wide, 1'b1);
    first   = be ? hi_elem : lo_elem;
    second  = be ? lo_elem : hi_elem;
  end
endmodule

// File: rtl/xpl_pair_load.sv
module xpl_pair_load
  import xpl_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter int SP_ALIGN_BYT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_valid,
  input  logic [31:0]         ins_word,
  input  logic                big_endian,
  input  logic [1:0]          dup_mode,
  output logic [RIDX_W-1:0]   rf_raddr,
  input  logic [XLEN-1:0]     rf_rdata,
  input  logic [XLEN-1:0]     sp_val,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [XLEN-1:0]     mem_req_addr,
  output logic [$clog2(XLEN/4)+1-1:0] mem_req_bytes,
  output logic                mem_req_tagchk,
  input  logic                mem_rsp_valid,
  input  logic [2*XLEN-1:0]   mem_rsp_data,
  output logic                wb0_en,
  output logic [RIDX_W-1:0]   wb0_idx,
  output logic [XLEN-1:0]     wb0_data,
  output logic                wb1_en,
  output logic [RIDX_W-1:0]   wb1_idx,
  output logic [XLEN-1:0]     wb1_data,
  output logic                undef_o,
  output logic                align_fault_o,
  input  logic                mon_clear,
  output logic                mon_valid,
  output logic [XLEN-1:0]     mon_addr,
  output logic [$clog2(XLEN/4)+1-1:0] mon_bytes
);
  localparam int DW     = 2 * XLEN;
  localparam int BW     = $clog2(XLEN/4) + 1;
  localparam int ALN    = $clog2(SP_ALIGN_BYT);
  localparam logic [RIDX_W-1:0] SP_IDX = '1;
  localparam logic [BW-1:0] BYTES_WIDE   = BW'(DW / 8);
  localparam logic [BW-1:0] BYTES_NARROW = BW'(DW / 16);

  xpl_dec_t   dec;
  xpl_state_e state;

  xpl_decode u_dec (.word(ins_word), .dec(dec));

  // Named events for the assertions
  logic use_sp, sp_misaligned, same_dst, dup_stop, accept;
  logic ev_undef, ev_fault, ev_go, ev_rsp;
  logic [XLEN-1:0] base_addr;
  logic [BW-1:0]   acc_bytes;

  always_comb begin
    use_sp        = dec.rbase == SP_IDX;
    base_addr     = use_sp ? sp_val : rf_rdata;
    sp_misaligned = use_sp && (sp_val[ALN-1:0] != '0);
    same_dst      = dec.rd0 == dec.rd1;
    dup_stop      = same_dst && (dup_mode != DUP_UNKNOWN);
    accept        = (state == ST_IDLE) && ins_valid;
    ev_undef      = accept && (!dec.hit ||
                    (same_dst && dup_mode != DUP_UNKNOWN && dup_mode != DUP_NOP));
    ev_fault      = accept && dec.hit && !dup_stop && sp_misaligned;
    ev_go         = accept && dec.hit && !dup_stop && !sp_misaligned;
    ev_rsp        = (state == ST_WAIT) && mem_rsp_valid;
    acc_bytes     = dec.wide ? BYTES_WIDE : BYTES_NARROW;
    rf_raddr      = dec.rbase;
  end

  xpl_monitor #(.AW(XLEN), .BW(BW)) u_mon (
    .clk(clk), .rst_n(rst_n),
    .arm(ev_go), .arm_addr(base_addr), .arm_bytes(acc_bytes),
    .clr(mon_clear),
    .valid(mon_valid), .addr(mon_addr), .bytes(mon_bytes)
  );

  logic            q_wide, q_be, q_garbage;
  logic [RIDX_W-1:0] q_rd0, q_rd1;
  logic [XLEN-1:0] split_first, split_second;

  xpl_split #(.XLEN(XLEN)) u_split (
    .wide(q_wide), .be(q_be), .rdata(mem_rsp_data),
    .first(split_first), .second(split_second)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      mem_req_addr   <= '0;
      mem_req_bytes  <= '0;
      mem_req_tagchk <= 1'b0;
      q_wide         <= 1'b0;
      q_be           <= 1'b0;
      q_garbage      <= 1'b0;
      q_rd0          <= '0;
      q_rd1          <= '0;
      undef_o        <= 1'b0;
      align_fault_o  <= 1'b0;
      wb0_en         <= 1'b0;
      wb1_en         <= 1'b0;
      wb0_idx        <= '0;
      wb1_idx        <= '0;
      wb0_data       <= '0;
      wb1_data       <= '0;
    end else begin
      undef_o       <= ev_undef;
      align_fault_o <= ev_fault;
      wb0_en        <= ev_rsp;
      wb1_en        <= ev_rsp && !q_garbage;
      if (ev_rsp) begin
        wb0_idx  <= q_rd0;
        wb1_idx  <= q_rd1;
        wb0_data <= q_garbage ? '1 : split_first;
        wb1_data <= split_second;
      end
      unique case (state)
        ST_IDLE: if (ev_go) begin
          state          <= ST_REQ;
          mem_req_addr   <= base_addr;
          mem_req_bytes  <= acc_bytes;
          mem_req_tagchk <= !use_sp;
          q_wide         <= dec.wide;
          q_be           <= big_endian;
          q_garbage      <= same_dst;
          q_rd0          <= dec.rd0;
          q_rd1          <= dec.rd1;
        end
        ST_REQ:  if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = state == ST_REQ;

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_armed_at_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> mon_valid && mon_addr == mem_req_addr
                             && mon_bytes == mem_req_bytes);
  assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault_o |-> !mem_req_valid && !wb0_en);
  assert_wb_pair_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wb1_en |-> wb0_en);
  assert_events_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_o, align_fault_o, wb0_en}));
  assert_req_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_bytes == BYTES_WIDE || mem_req_bytes == BYTES_NARROW));
endmodule

// File: tb/tb_xpl_pair_load.sv
`timescale 1ns/1ps
module tb_xpl_pair_load;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         ins_valid = 1'b0;
  logic [31:0]  ins_word = '0;
  logic         big_endian = 1'b0;
  logic [1:0]   dup_mode = 2'd0;
  logic [4:0]   rf_raddr;
  logic [63:0]  rf_rdata = '0;
  logic [63:0]  sp_val = '0;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [63:0]  mem_req_addr;
  logic [4:0]   mem_req_bytes;
  logic         mem_req_tagchk;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;
  logic         wb0_en, wb1_en, undef_o, align_fault_o, mon_valid;
  logic [4:0]   wb0_idx, wb1_idx, mon_bytes;
  logic [63:0]  wb0_data, wb1_data, mon_addr;
  logic         mon_clear = 1'b0;

  xpl_pair_load dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
    .big_endian(big_endian), .dup_mode(dup_mode), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .sp_val(sp_val), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_bytes(mem_req_bytes), .mem_req_tagchk(mem_req_tagchk),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .wb0_en(wb0_en), .wb0_idx(wb0_idx), .wb0_data(wb0_data),
    .wb1_en(wb1_en), .wb1_idx(wb1_idx), .wb1_data(wb1_data),
    .undef_o(undef_o), .align_fault_o(align_fault_o), .mon_clear(mon_clear),
    .mon_valid(mon_valid), .mon_addr(mon_addr), .mon_bytes(mon_bytes)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic check(input logic ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic wide, input logic [4:0] rt,
                                          input logic [4:0] rt2, input logic [4:0] rn);
    return {1'b1, wide, 6'b001000, 3'b011, 5'b11111, 1'b0, rt2, rn, rt};
  endfunction

  // Expected element: shift the wanted element down, then mask to its width
  function automatic logic [63:0] exp_elem(input logic wide, input logic [127:0] d,
                                           input int k);
    logic [127:0] s;
    int w;
    w = wide ? 64 : 32;
    s = d >> (w * k);
    return wide ? s[63:0] : {32'h0, s[31:0]};
  endfunction

  typedef struct packed {
    logic         wide;
    logic         be;
    logic [4:0]   rt;
    logic [4:0]   rt2;
    logic [4:0]   rn;
    logic [63:0]  base;
    logic [127:0] data;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b0, 1'b0, 5'd1,  5'd2,  5'd3,  64'h0000_0000_0000_1000, 128'h0123_4567_89AB_CDEF_1111_2222_3333_4444},
    '{1'b0, 1'b1, 5'd4,  5'd9,  5'd0,  64'h0000_0000_0000_2008, 128'hDEAD_BEEF_0000_0000_5555_6666_7777_8888},
    '{1'b1, 1'b0, 5'd10, 5'd11, 5'd5,  64'h0000_7000_0000_0040, 128'hA0A1_A2A3_A4A5_A6A7_B0B1_B2B3_B4B5_B6B7},
    '{1'b1, 1'b1, 5'd30, 5'd0,  5'd12, 64'hFFFF_0000_0000_0010, 128'hC0C1_C2C3_C4C5_C6C7_D0D1_D2D3_D4D5_D6D7},
    '{1'b1, 1'b0, 5'd7,  5'd8,  5'd31, 64'h0000_0000_8000_0010, 128'h1234_0000_0000_5678_9ABC_0000_0000_DEF0},
    '{1'b0, 1'b1, 5'd20, 5'd21, 5'd31, 64'h0000_0000_0000_3000, 128'h0000_0000_0000_0000_FEDC_BA98_7654_3210}
  };

  // Full access; caller places inputs at a negedge with the unit idle.
  task automatic run_access(input vec_t v, input logic probe_busy);
    logic [63:0] e0, e1;
    ins_word   = mk_word(v.wide, v.rt, v.rt2, v.rn);
    big_endian = v.be;
    if (v.rn == 5'd31) begin sp_val = v.base; rf_rdata = 64'hBAD0_BAD0_BAD0_BAD0; end
    else begin rf_rdata = v.base; sp_val = 64'h0000_0000_0000_0007; end
    ins_valid = 1'b1;
    #1 check(rf_raddr == v.rn, "R2 rf_raddr", rf_raddr, v.rn);
    @(negedge clk);
    ins_valid = 1'b0;
    check(mem_req_valid == 1'b1, "R6 req raised", mem_req_valid, 1);
    check(mem_req_addr == v.base, "R2 req addr", mem_req_addr, v.base);
    check(mem_req_tagchk == (v.rn != 5'd31), "R2 tagchk", mem_req_tagchk, v.rn != 5'd31);
    check(mem_req_bytes == (v.wide ? 5'd16 : 5'd8), "R3 bytes", mem_req_bytes, v.wide ? 16 : 8);
    check(mon_valid && mon_addr == v.base, "R5 monitor armed", mon_addr, v.base);
    check(mon_bytes == (v.wide ? 5'd16 : 5'd8), "R5 monitor bytes", mon_bytes, v.wide ? 16 : 8);
    if (probe_busy) begin
      ins_word  = mk_word(1'b1, 5'd17, 5'd18, 5'd19);
      ins_valid = 1'b1;
    end
    @(negedge clk);
    ins_valid = 1'b0;
    check(mem_req_valid && mem_req_addr == v.base, "R6 req held", mem_req_addr, v.base);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(mem_req_valid == 1'b0, "R6 req dropped", mem_req_valid, 0);
    if (probe_busy) begin
      ins_word  = mk_word(1'b0, 5'd22, 5'd23, 5'd24);
      ins_valid = 1'b1;
    end
    mem_rsp_data  = v.data;
    mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    ins_valid     = 1'b0;
    e0 = exp_elem(v.wide, v.data, v.be ? 1 : 0);
    e1 = exp_elem(v.wide, v.data, v.be ? 0 : 1);
    check(wb0_en && wb1_en, "R13 both enables", {wb0_en, wb1_en}, 2'b11);
    check(wb0_idx == v.rt && wb1_idx == v.rt2, "R7 indices", {wb0_idx, wb1_idx}, {v.rt, v.rt2});
    check(wb0_data == e0, v.be ? "R8 port0 data" : "R7 port0 data", wb0_data, e0);
    check(wb1_data == e1, v.be ? "R8 port1 data" : "R7 port1 data", wb1_data, e1);
    @(negedge clk);
    check(!wb0_en && !wb1_en, "R13 single pulse", {wb0_en, wb1_en}, 0);
    if (probe_busy)
      check(!mem_req_valid, "R12 busy word ignored", mem_req_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!mem_req_valid && !wb0_en && !wb1_en && !undef_o && !align_fault_o && !mon_valid,
          "R1 reset state", {mem_req_valid, wb0_en, wb1_en, undef_o, align_fault_o, mon_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) run_access(VECS[i], 1'b0);

    // R12: words offered while busy start nothing
    run_access(VECS[2], 1'b1);

    // R1: bit 15 set -> not recognised
    ins_word = mk_word(1'b0, 5'd1, 5'd2, 5'd3) | 32'h0000_8000;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    check(undef_o == 1'b1, "R1 undef on bad word", undef_o, 1);
    check(!mem_req_valid, "R1 no request", mem_req_valid, 0);
    @(negedge clk);
    check(!undef_o && !wb0_en, "R1 undef one cycle", undef_o, 0);

    // R5: clear drops the reservation
    mon_clear = 1'b1;
    @(negedge clk);
    mon_clear = 1'b0;
    check(!mon_valid, "R5 clear", mon_valid, 0);

    // R4: misaligned stack pointer
    ins_word = mk_word(1'b1, 5'd1, 5'd2, 5'd31);
    sp_val = 64'h0000_0000_0000_1008;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    check(align_fault_o, "R4 fault raised", align_fault_o, 1);
    check(!mem_req_valid && !mon_valid, "R4 no req no arm", {mem_req_valid, mon_valid}, 0);
    @(negedge clk);
    check(!align_fault_o && !mem_req_valid, "R4 back idle", {align_fault_o, mem_req_valid}, 0);

    // R5: arm, then clear and arm in the same cycle -> arm wins
    run_access(VECS[0], 1'b0);
    mon_clear = 1'b1;
    ins_word = mk_word(1'b0, 5'd1, 5'd2, 5'd3);
    rf_rdata = 64'h0000_0000_0000_4440;
    big_endian = 1'b0;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    mon_clear = 1'b0;
    check(mon_valid && mon_addr == 64'h4440, "R5 arm beats clear", mon_addr, 64'h4440);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    @(negedge clk);

    // R9: equal destinations, unknown-value policy
    dup_mode = 2'd0;
    ins_word = mk_word(1'b1, 5'd7, 5'd7, 5'd2);
    rf_rdata = 64'h0000_0000_0000_5550;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    check(mem_req_valid && mon_addr == 64'h5550, "R9 access performed", mem_req_addr, 64'h5550);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_data = 128'h1;
    mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check(wb0_en && !wb1_en, "R9 port0 only", {wb0_en, wb1_en}, 2'b10);
    check(wb0_idx == 5'd7 && wb0_data == '1, "R9 all ones", wb0_data, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);

    // R10: equal destinations, undefined policy; monitor unchanged
    dup_mode = 2'd1;
    ins_word = mk_word(1'b0, 5'd9, 5'd9, 5'd4);
    rf_rdata = 64'h0000_0000_0000_9990;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    check(undef_o && !mem_req_valid, "R10 undef no req", {undef_o, mem_req_valid}, 2'b10);
    check(mon_valid && mon_addr == 64'h5550 && mon_bytes == 5'd16, "R10 monitor kept", mon_addr, 64'h5550);
    @(negedge clk);

    // R11: equal destinations, no-op policy
    dup_mode = 2'd2;
    ins_word = mk_word(1'b1, 5'd3, 5'd3, 5'd31);
    sp_val = 64'h0000_0000_0000_0003;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(!undef_o && !align_fault_o && !mem_req_valid && !wb0_en && !wb1_en,
            "R11 silent", {undef_o, align_fault_o, mem_req_valid, wb0_en, wb1_en}, 0);
      @(negedge clk);
    end
    check(mon_addr == 64'h5550, "R11 monitor kept", mon_addr, 64'h5550);
    dup_mode = 2'd0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule